// File: doc/BRIEF.md
# SD card single-block transfer engine

This block moves one fixed-length data block between a local byte buffer and an SD card running in SPI mode. It runs only after the card has accepted the read or write command. Every card access goes through a byte-exchange port. The engine offers one byte to send and holds the offer until the serialiser acknowledges it. In the acknowledge cycle the serialiser returns the byte it received. The engine drives chip select itself.

For a read, the engine clocks idle bytes until the start token arrives, then writes the payload into the buffer through a write port (address, data, enable). It clocks in the two checksum bytes and discards them. For a write, it sends the start token, the payload fetched from a combinational buffer read port, and two filler bytes in place of the checksum. It then decodes the card's data response token and waits while the card holds the line low (busy).

Both waiting phases are bounded by limits supplied at the ports. Every transfer ends the same way, success or failure: chip select is released, one trailing idle byte is clocked, and a done pulse is given with a three-bit status.

Top module: `sd_blk_xfer`

## Requirements
- R1: After reset, cs_n_o is 1 and xchg_req_o, done_o, buf_we_o, err_o are 0, with status_o equal to 0.
- R2: A read (start_i with dir_wr_i=0) sends 0xFF in every exchange and stores nothing until a received byte equals 0xFE.
- R3: After the 0xFE of a read, exactly PAYLOAD_LEN received bytes are written to the buffer, at addresses 0 to PAYLOAD_LEN-1 in arrival order, while chip select is low.
- R4: After the payload of a read, two more bytes are clocked in and not stored. Then chip select goes high for one 0xFF exchange, and done_o pulses with status 0.
- R5: A write (dir_wr_i=1) sends 0xFE, then buffer bytes 0 to PAYLOAD_LEN-1, then 0xFF, 0xFF, then one 0xFF exchange whose received byte is the response token. All of these run with chip select low.
- R6: A token whose low five bits are 5'b00101 is accepted whatever bits 7:5 hold, and the engine enters the busy wait.
- R7: If the low five bits of the token are 5'b01011, the status is 2. If they are 5'b01101, the status is 3. Any other value gives status 4. In each case chip select goes high for one 0xFF exchange, then done_o pulses.
- R8: In the busy wait the engine sends 0xFF while it receives 0x00. The first non-zero byte ends the wait, then comes one 0xFF exchange with chip select high, then done_o with status 0.
- R9: If hunt_limit_i bytes in a row arrive without a 0xFE, the read ends with status 1 and nothing stored, followed by the chip-select-high trailer.
- R10: If busy_limit_i zero bytes arrive in a row, the write ends with status 5, followed by the chip-select-high trailer.
- R11: While xchg_req_o is high and xchg_ack_i is low, xchg_req_o, xchg_tx_o and cs_n_o hold their values on the next cycle.
- R12: start_i has no effect while a transfer is in progress.
- R13: done_o is a single-cycle pulse. err_o is 1 exactly when status_o is non-zero. status_o holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| dir_wr_i | input | 1 | 1 = write block to card, 0 = read block |
| hunt_limit_i | input | TMO_W | Maximum bytes examined for the start token |
| busy_limit_i | input | TMO_W | Maximum busy bytes accepted after a write |
| xchg_req_o | output | 1 | Byte exchange request, held until acknowledged |
| xchg_tx_o | output | 8 | Byte to send |
| xchg_ack_i | input | 1 | Exchange complete, xchg_rx_i valid this cycle |
| xchg_rx_i | input | 8 | Byte received in the exchange |
| cs_n_o | output | 1 | Card chip select, active low |
| buf_we_o | output | 1 | Buffer write enable (read transfers) |
| buf_waddr_o | output | IDX_W | Buffer write address |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_raddr_o | output | IDX_W | Buffer read address (write transfers) |
| buf_rdata_i | input | 8 | Buffer read data, combinational from buf_raddr_o |
| done_o | output | 1 | Transfer finished pulse |
| err_o | output | 1 | Last transfer ended in error |
| status_o | output | 3 | 0 ok, 1 token timeout, 2 CRC reject, 3 write reject, 4 bad token, 5 busy timeout |

## Verification
The engine takes a request one cycle after the previous acknowledge and drops it on the clock edge that samples the acknowledge. The card model therefore compares the outgoing byte and chip select in the cycle it raises the acknowledge, against the next expected item in the queue. A payload byte reaches the buffer write port one cycle after its acknowledge, and the monitor checks its address in that cycle. done_o and status_o are registered on the acknowledge of the trailer byte, so they are sampled in the following cycle. The status is checked again one cycle later to show that it holds.

// File: rtl/sd_blk_pkg.sv
package sd_blk_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HUNT, ST_RD_DATA, ST_RD_CRC,
    ST_WR_TOKEN, ST_WR_DATA, ST_WR_CRC, ST_WR_RESP, ST_WR_BUSY, ST_TAIL
  } xfer_state_e;

  typedef enum logic [2:0] {
    STS_OK       = 3'd0,
    STS_HUNT_TMO = 3'd1,
    STS_CRC_REJ  = 3'd2,
    STS_WR_REJ   = 3'd3,
    STS_BAD_TOK  = 3'd4,
    STS_BUSY_TMO = 3'd5
  } xfer_status_e;

  localparam logic [7:0] START_TOKEN = 8'hFE;
  localparam logic [7:0] FILL_BYTE   = 8'hFF;
endpackage

// File: rtl/sd_blk_cnt.sv
module sd_blk_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/sd_blk_tok.sv
module sd_blk_tok
  import sd_blk_pkg::*;
(
  input  logic [4:0]   tok_lo_i,
  output logic         accept_o,
  output xfer_status_e code_o
);
  // bit0 must be 1, bit4 must be 0; bits 3:1 carry the card's verdict
  always_comb begin
    accept_o = 1'b0;
    code_o   = STS_BAD_TOK;
    unique case (tok_lo_i)
      5'b00101: begin accept_o = 1'b1; code_o = STS_OK; end
      5'b01011: code_o = STS_CRC_REJ;
      5'b01101: code_o = STS_WR_REJ;
      default:  code_o = STS_BAD_TOK;
    endcase
  end
endmodule

// File: rtl/sd_blk_xchg.sv
module sd_blk_xchg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       issue_i,
  input  logic [7:0] tx_i,
  input  logic       ack_i,
  output logic       req_o,
  output logic [7:0] tx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      tx_o  <= 8'hFF;
    end else if (req_o && ack_i) begin
      req_o <= 1'b0;
    end else if (issue_i && !req_o) begin
      req_o <= 1'b1;
      tx_o  <= tx_i;
    end
  end
endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
  import sd_blk_pkg::*;
#(
  parameter  int unsigned PAYLOAD_LEN = 512,
  parameter  int unsigned TMO_W       = 16,
  localparam int unsigned IDX_W       = $clog2(PAYLOAD_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dir_wr_i,
  input  logic [TMO_W-1:0] hunt_limit_i,
  input  logic [TMO_W-1:0] busy_limit_i,
  output logic             xchg_req_o,
  output logic [7:0]       xchg_tx_o,
  input  logic             xchg_ack_i,
  input  logic [7:0]       xchg_rx_i,
  output logic             cs_n_o,
  output logic             buf_we_o,
  output logic [IDX_W-1:0] buf_waddr_o,
  output logic [7:0]       buf_wdata_o,
  output logic [IDX_W-1:0] buf_raddr_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       status_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAYLOAD_LEN - 1);
  localparam logic [IDX_W-1:0] CRC_LAST = IDX_W'(1);

  xfer_state_e  state_q, state_d;
  xfer_status_e status_q, status_d;
  logic         done_q, done_d;
  logic         acked, issue;
  logic [7:0]   tx_sel;
  logic         idx_clr, idx_inc, tmo_clr, tmo_inc;
  logic [IDX_W-1:0] idx;
  logic [TMO_W-1:0] tmo;
  logic         tok_ok;
  xfer_status_e tok_code;
  logic         hunt_last, busy_last;

  sd_blk_xchg u_xchg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .issue_i(issue),
    .tx_i   (tx_sel),
    .ack_i  (xchg_ack_i),
    .req_o  (xchg_req_o),
    .tx_o   (xchg_tx_o)
  );

  sd_blk_cnt #(.W(IDX_W)) u_idx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (idx_clr),
    .inc_i (idx_inc),
    .cnt_o (idx)
  );

  sd_blk_cnt #(.W(TMO_W)) u_tmo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmo_clr),
    .inc_i (tmo_inc),
    .cnt_o (tmo)
  );

  sd_blk_tok u_tok (
    .tok_lo_i(xchg_rx_i[4:0]),
    .accept_o(tok_ok),
    .code_o  (tok_code)
  );

  assign acked     = xchg_req_o && xchg_ack_i;
  assign issue     = (state_q != ST_IDLE) && !xchg_req_o;
  assign hunt_last = (tmo == hunt_limit_i - TMO_W'(1));
  assign busy_last = (tmo == busy_limit_i - TMO_W'(1));

  always_comb begin
    unique case (state_q)
      ST_WR_TOKEN: tx_sel = START_TOKEN;
      ST_WR_DATA:  tx_sel = buf_rdata_i;
      default:     tx_sel = FILL_BYTE;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    done_d   = 1'b0;
    idx_clr  = 1'b0;
    idx_inc  = 1'b0;
    tmo_clr  = 1'b0;
    tmo_inc  = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_d  = dir_wr_i ? ST_WR_TOKEN : ST_HUNT;
        status_d = STS_OK;
        idx_clr  = 1'b1;
        tmo_clr  = 1'b1;
      end
    end else if (acked) begin
      unique case (state_q)
        ST_HUNT: begin
          if (xchg_rx_i == START_TOKEN) begin
            state_d = ST_RD_DATA;
            idx_clr = 1'b1;
          end else if (hunt_last) begin
            state_d  = ST_TAIL;
            status_d = STS_HUNT_TMO;
          end else begin
            tmo_inc = 1'b1;
          end
        end
        ST_RD_DATA: begin
          if (idx == LAST_IDX) begin
            state_d = ST_RD_CRC;
            idx_clr = 1'b1;
          end else begin
            idx_inc = 1'b1;
          end
        end
        ST_RD_CRC: begin
          if (idx == CRC_LAST) state_d = ST_TAIL;
          else                 idx_inc = 1'b1;
        end
        ST_WR_TOKEN: begin
          state_d = ST_WR_DATA;
          idx_clr = 1'b1;
        end
        ST_WR_DATA: begin
          if (idx == LAST_IDX) begin
            state_d = ST_WR_CRC;
            idx_clr = 1'b1;
          end else begin
            idx_inc = 1'b1;
          end
        end
        ST_WR_CRC: begin
          if (idx == CRC_LAST) state_d = ST_WR_RESP;
          else                 idx_inc = 1'b1;
        end
        ST_WR_RESP: begin
          if (tok_ok) begin
            state_d = ST_WR_BUSY;
            tmo_clr = 1'b1;
          end else begin
            state_d  = ST_TAIL;
            status_d = tok_code;
          end
        end
        ST_WR_BUSY: begin
          if (xchg_rx_i != 8'h00) begin
            state_d = ST_TAIL;
          end else if (busy_last) begin
            state_d  = ST_TAIL;
            status_d = STS_BUSY_TMO;
          end else begin
            tmo_inc = 1'b1;
          end
        end
        ST_TAIL: begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      status_q    <= STS_OK;
      done_q      <= 1'b0;
      buf_we_o    <= 1'b0;
      buf_waddr_o <= '0;
      buf_wdata_o <= '0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      done_q   <= done_d;
      buf_we_o <= acked && (state_q == ST_RD_DATA);
      if (acked && (state_q == ST_RD_DATA)) begin
        buf_waddr_o <= idx;
        buf_wdata_o <= xchg_rx_i;
      end
    end
  end

  assign cs_n_o      = (state_q == ST_IDLE) || (state_q == ST_TAIL);
  assign buf_raddr_o = idx;
  assign done_o      = done_q;
  assign status_o    = status_q;
  assign err_o       = (status_q != STS_OK);
endmodule

// File: rtl/sd_blk_xfer_chk.sv
module sd_blk_xfer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       xchg_req_o,
  input logic       xchg_ack_i,
  input logic [7:0] xchg_tx_o,
  input logic       cs_n_o,
  input logic       buf_we_o,
  input logic       done_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xchg_req_o && !xchg_ack_i) |=> xchg_req_o); // R11
  AST_TX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xchg_req_o && !xchg_ack_i) |=> $stable(xchg_tx_o)); // R11
  AST_CS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xchg_req_o && !xchg_ack_i) |=> $stable(cs_n_o)); // R11
  AST_STORE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> !cs_n_o); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R13
  AST_DONE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && !xchg_req_o)); // R4
endmodule

bind sd_blk_xfer sd_blk_xfer_chk u_chk (.*);

// File: tb/sd_blk_xfer_test.sv
module sd_blk_xfer_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LEN = 512;
  localparam int  AW  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_wr = 1'b0;
  logic [15:0] hunt_lim = 16'd64, busy_lim = 16'd64;
  logic xchg_req, xchg_ack;
  logic [7:0] xchg_tx, xchg_rx;
  logic cs_n, buf_we, done, err;
  logic [AW-1:0] waddr, raddr;
  logic [7:0] wdata, rdata;
  logic [2:0] status;

  logic [7:0] wr_mem [LEN];
  logic [7:0] rd_mem [LEN];
  logic [16:0] exp_q [$];   // {cs_n, expected tx, byte the card returns}
  int vectors = 0, miscompares = 0;
  int we_cnt = 0, next_addr = 0, nxch = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rdata = wr_mem[raddr];

  sd_blk_xfer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_wr_i(dir_wr),
    .hunt_limit_i(hunt_lim), .busy_limit_i(busy_lim),
    .xchg_req_o(xchg_req), .xchg_tx_o(xchg_tx), .xchg_ack_i(xchg_ack), .xchg_rx_i(xchg_rx),
    .cs_n_o(cs_n), .buf_we_o(buf_we), .buf_waddr_o(waddr), .buf_wdata_o(wdata),
    .buf_raddr_o(raddr), .buf_rdata_i(rdata),
    .done_o(done), .err_o(err), .status_o(status)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // card model: compares each outgoing byte against the queue, answers with a varying delay
  initial begin
    xchg_ack = 1'b0;
    xchg_rx  = 8'hFF;
    forever begin
      @(negedge clk);
      xchg_ack = 1'b0;
      if (xchg_req) begin
        repeat (nxch % 3) @(negedge clk);
        nxch++;
        if (exp_q.size() == 0) begin
          check("R11 unexpected exchange", {23'd0, cs_n, xchg_tx}, 32'h1FF);
          xchg_rx = 8'hFF;
        end else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          check("R2/R5 chip select", {31'd0, cs_n}, {31'd0, e[16]});
          check("R2/R5 sent byte", {24'd0, xchg_tx}, {24'd0, e[15:8]});
          xchg_rx = e[7:0];
        end
        xchg_ack = 1'b1;
      end
    end
  end

  // buffer write monitor
  initial forever begin
    @(negedge clk);
    if (buf_we) begin
      check("R3 store address order", {23'd0, waddr}, next_addr);
      rd_mem[waddr] = wdata;
      next_addr++;
      we_cnt++;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic push(logic c, logic [7:0] tx, logic [7:0] rx);
    exp_q.push_back({c, tx, rx});
  endtask

  task automatic kick(logic wr);
    we_cnt = 0; next_addr = 0;
    @(negedge clk);
    start = 1'b1; dir_wr = wr;
    @(negedge clk);
    start = 1'b0; dir_wr = 1'b0;
  endtask

  task automatic wait_done(logic [2:0] exp_sts, string req);
    int g = 0;
    while (!done && g < 20000) begin @(negedge clk); g++; end
    check({req, " done"}, {31'd0, done}, 1);
    check({req, " status"}, {29'd0, status}, {29'd0, exp_sts});
    check("R13 err flag", {31'd0, err}, {31'd0, exp_sts != 3'd0});
    check("R11 queue drained", exp_q.size(), 0);
    @(negedge clk);
    check("R13 done pulse width", {31'd0, done}, 0);
    check("R13 status held", {29'd0, status}, {29'd0, exp_sts});
    exp_q.delete();
  endtask

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * s + 3 * s + (i >> 3)) & 8'hFF);
  endfunction

  task automatic read_blk(int lead, int s, logic poke);
    for (int i = 0; i < lead; i++) push(1'b0, 8'hFF, (i % 2) ? 8'h00 : 8'hFF);
    push(1'b0, 8'hFF, 8'hFE);
    for (int i = 0; i < LEN; i++) push(1'b0, 8'hFF, pat(i, s));
    push(1'b0, 8'hFF, 8'h5A);
    push(1'b0, 8'hFF, 8'hC3);
    push(1'b1, 8'hFF, 8'hFF);
    kick(1'b0);
    if (poke) begin
      // R12: start with write direction in mid-transfer must be ignored
      repeat (40) @(negedge clk);
      start = 1'b1; dir_wr = 1'b1;
      @(negedge clk);
      start = 1'b0; dir_wr = 1'b0;
    end
    wait_done(3'd0, "R4 read");
    check("R3 stored byte count", we_cnt, LEN);
    for (int i = 0; i < LEN; i++)
      if (rd_mem[i] !== pat(i, s)) check("R3 stored payload", {i, rd_mem[i]}, {i, pat(i, s)});
  endtask

  task automatic write_blk(int s, logic [7:0] resp, int nbusy, logic [2:0] exp_sts, string req);
    for (int i = 0; i < LEN; i++) wr_mem[i] = pat(i, s);
    push(1'b0, 8'hFE, 8'hFF);
    for (int i = 0; i < LEN; i++) push(1'b0, pat(i, s), 8'hFF);
    push(1'b0, 8'hFF, 8'hFF);
    push(1'b0, 8'hFF, 8'hFF);
    push(1'b0, 8'hFF, resp);
    if ((resp & 8'h1F) == 8'h05) begin
      for (int k = 0; k < nbusy && k < int'(busy_lim); k++) push(1'b0, 8'hFF, 8'h00);
      if (nbusy < int'(busy_lim)) push(1'b0, 8'hFF, 8'h3C);
    end
    push(1'b1, 8'hFF, 8'hFF);
    kick(1'b1);
    wait_done(exp_sts, req);
    check({req, " no buffer stores"}, we_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cs_n after reset", {31'd0, cs_n}, 1);
    check("R1 req after reset", {31'd0, xchg_req}, 0);
    check("R1 done/we/err after reset", {29'd0, done, buf_we, err}, 0);
    check("R1 status after reset", {29'd0, status}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    read_blk(3, 7, 1'b1);                       // R2 R3 R4 R12
    read_blk(0, 13, 1'b0);                      // R2 token on first byte
    hunt_lim = 16'd5;                           // R9
    for (int i = 0; i < 5; i++) push(1'b0, 8'hFF, 8'hFF);
    push(1'b1, 8'hFF, 8'hFF);
    kick(1'b0);
    wait_done(3'd1, "R9 token timeout");
    check("R9 nothing stored", we_cnt, 0);
    hunt_lim = 16'd64;

    write_blk(5, 8'hE5, 3, 3'd0, "R6 R8 accepted with busy");
    write_blk(9, 8'h05, 0, 3'd0, "R8 no busy");
    write_blk(11, 8'h0B, 0, 3'd2, "R7 crc reject");
    write_blk(17, 8'hAD, 0, 3'd3, "R7 write reject");
    write_blk(19, 8'h07, 0, 3'd4, "R7 bad token");
    busy_lim = 16'd4;
    write_blk(23, 8'h25, 10, 3'd5, "R10 busy timeout");
    busy_lim = 16'd64;
    read_blk(1, 29, 1'b0);                      // R13 status cleared by new start

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule